// File: doc/BRIEF.md
# Vector Logic, Arithmetic and Shift Unit

This unit executes three instruction groups of a small vector rendering engine: bitwise logic, integer arithmetic and shifts. It owns a register file of 32-bit registers (128 by default) and, for each accepted instruction, walks over a run of consecutive registers, handling one element per clock cycle. The second operand of every element comes from one of three places, depending on the sub-operation. It can be a vector register that advances with the element index, a scalar register that stays fixed, or a 7-bit immediate that is sign-extended to 32 bits. Beyond the plain element-wise operations, the unit offers a reduction sum, a conditional add/subtract used to form an absolute value, and a funnel left shift that draws on two neighbouring registers.

The host issues an instruction by pulsing `start` with the instruction word while the unit is idle. `busy` then stays high for exactly count+1 cycles, and `done` pulses for one cycle as `busy` falls. A host port loads and reads the register file while the unit is idle. Register 0 always reads zero.

Top module: `vec_lasu`

## Requirements
- R1: After reset every register reads zero, and `busy` and `done` are low.
- R2: A `start` seen while idle raises `busy` on the next cycle. `busy` stays high for count+1 cycles and then falls, with `done` high for exactly that one following cycle. A `start` seen while busy is ignored.
- R3: Instruction fields are: group in bits 31:28, count in 27:24 (count+1 elements), sub-operation in 23:21, source A in 20:14, destination in 13:7 and source B in 6:0. Element i reads A+i and writes D+i, with register numbers wrapping modulo the register count.
- R4: Vector forms read register B+i. Scalar forms read register B for every element. Immediate forms use bits 6:0 sign-extended to 32 bits.
- R5: Group 0xB (logic) sub-operations: 0 AND vector, 1 AND scalar, 2 AND immediate, 3 XOR vector, 4 XOR scalar, 5 XOR immediate, 6 OR vector, 7 OR scalar.
- R6: Group 0xA (arithmetic) sub-operations: 0/1/2 are A+B with a vector/scalar/immediate B, and 4/5/6 are A-B with a vector/scalar/immediate B, all modulo 2^32.
- R7: Arithmetic sub-operation 3 writes only register D, with scalar register B plus the sum of A[0..count].
- R8: Arithmetic sub-operation 7 takes a vector B and computes A-B where B is negative and A+B otherwise, so with A = R0 it yields |B|.
- R9: Group 0xC (shift) sub-operations 0/1 are logical right, 2/3 arithmetic right and 4/5 logical left, each by a vector/immediate amount. The amount is the low 5 bits of B.
- R10: Shift sub-operations 6 (amount from scalar register B) and 7 (immediate amount) write the upper 32 bits of the 64-bit value {A[i], A[i+1]} shifted left by the amount.
- R11: Elements run in order, and each element reads register contents that already include the writes of earlier elements of the same instruction.
- R12: Writes to register 0, whether from an instruction or from the host port, are dropped, and register 0 reads zero.
- R13: Host port writes while busy are dropped. Instructions of any other group take the usual count+1 cycles and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Issue `instr` (taken only when idle) |
| instr | input | 32 | Instruction word |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| host_we | input | 1 | Host register write enable (idle only) |
| host_addr | input | AW (7) | Host register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Register contents at `host_addr` (combinational) |

## Verification
The bench builds the unit with its defaults: 128 registers, 32-bit data, a 4-bit count and a 7-bit immediate. With these values, runs of up to 16 elements can start near register 127 and wrap across it onto register 0, where the write must be dropped. The longest reduction and the full immediate range, from -64 to 63, are also reachable. Shift amounts of 0 and 31 exercise both ends of the funnel shift.

// File: rtl/vec_lasu.sv
module vec_lasu #(
  parameter int NREG = 128,
  parameter int DW   = 32,
  parameter int CW   = 4,
  parameter int IMMW = 7,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [31:0]   instr,
  output logic          busy,
  output logic          done,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata
);
  localparam int SW = $clog2(DW);
  localparam logic [3:0] GRP_ARI = 4'hA;
  localparam logic [3:0] GRP_LOG = 4'hB;
  localparam logic [3:0] GRP_SHF = 4'hC;

  logic [DW-1:0] rf [NREG];
  logic [31:0]   ir;
  logic [CW-1:0] idx;
  logic          run;
  logic          done_q;
  logic [DW-1:0] acc;

  wire [3:0]    grp = ir[31:28];
  wire [CW-1:0] cnt = ir[24 +: CW];
  wire [2:0]    op  = ir[23:21];
  wire [AW-1:0] fa  = ir[14 +: AW];
  wire [AW-1:0] fd  = ir[7 +: AW];
  wire [AW-1:0] fb  = ir[0 +: AW];
  wire          last = (idx == cnt);

  wire [AW-1:0] ea  = fa + AW'(idx);
  wire [AW-1:0] ea1 = ea + AW'(1);
  wire [AW-1:0] ed  = fd + AW'(idx);
  wire [AW-1:0] eb  = fb + AW'(idx);

  wire [DW-1:0] a    = rf[ea];
  wire [DW-1:0] a1   = rf[ea1];
  wire [DW-1:0] imm  = {{(DW-IMMW){ir[IMMW-1]}}, ir[IMMW-1:0]};

  logic          b_vec, b_imm;
  always_comb begin
    b_vec = 1'b0;
    b_imm = 1'b0;
    unique case (grp)
      GRP_LOG: begin
        b_vec = (op == 3'd0) || (op == 3'd3) || (op == 3'd6);
        b_imm = (op == 3'd2) || (op == 3'd5);
      end
      GRP_ARI: begin
        b_vec = (op == 3'd0) || (op == 3'd4) || (op == 3'd7);
        b_imm = (op == 3'd2) || (op == 3'd6);
      end
      GRP_SHF: begin
        b_vec = !op[0] && (op != 3'd6);
        b_imm = op[0];
      end
      default: ;
    endcase
  end

  wire [DW-1:0]   b   = b_vec ? rf[eb] : (b_imm ? imm : rf[fb]);
  wire [SW-1:0]   amt = b[SW-1:0];
  wire [2*DW-1:0] fun = {a, a1} << amt;
  wire            is_sum = (grp == GRP_ARI) && (op == 3'd3);

  logic [DW-1:0] res;
  logic          valid;
  always_comb begin
    res   = '0;
    valid = 1'b1;
    unique case (grp)
      GRP_LOG: begin
        unique case (op)
          3'd0, 3'd1, 3'd2: res = a & b;
          3'd3, 3'd4, 3'd5: res = a ^ b;
          default:          res = a | b;
        endcase
      end
      GRP_ARI: begin
        unique case (op)
          3'd0, 3'd1, 3'd2: res = a + b;
          3'd3:             res = ((idx == '0) ? b : acc) + a;
          3'd7:             res = b[DW-1] ? a - b : a + b;
          default:          res = a - b;
        endcase
      end
      GRP_SHF: begin
        unique case (op[2:1])
          2'd0:    res = a >> amt;
          2'd1:    res = DW'($signed(a) >>> amt);
          2'd2:    res = a << amt;
          default: res = fun[2*DW-1:DW];
        endcase
      end
      default: valid = 1'b0;
    endcase
  end

  wire [AW-1:0] waddr = is_sum ? fd : ed;
  wire          we    = run && valid && (!is_sum || last) && (waddr != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) rf[r] <= '0;
      ir     <= '0;
      idx    <= '0;
      run    <= 1'b0;
      done_q <= 1'b0;
      acc    <= '0;
    end else begin
      done_q <= 1'b0;
      if (run) begin
        if (we) rf[waddr] <= res;
        acc <= res;
        idx <= idx + CW'(1);
        if (last) begin
          run    <= 1'b0;
          done_q <= 1'b1;
        end
      end else begin
        if (host_we && host_addr != '0) rf[host_addr] <= host_wdata;
        if (start) begin
          ir  <= instr;
          idx <= '0;
          run <= 1'b1;
        end
      end
    end
  end

  assign busy       = run;
  assign done       = done_q;
  assign host_rdata = rf[host_addr];
endmodule

// File: rtl/vec_lasu_chk.sv
module vec_lasu_chk #(
  parameter int CW = 4,
  parameter int AW = 7,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [31:0]   instr,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] host_addr,
  input logic [DW-1:0] host_rdata
);
  logic [CW:0] len, exp_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len     <= '0;
      exp_len <= '0;
    end else if (start && !busy) begin
      len     <= '0;
      exp_len <= {1'b0, instr[24 +: CW]} + (CW+1)'(1);
    end else if (busy) begin
      len <= len + (CW+1)'(1);
    end
  end

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  assert_fall_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_run_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (len == exp_len));
  assert_r0_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == '0) |-> (host_rdata == '0));
endmodule

bind vec_lasu vec_lasu_chk #(.CW(CW), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .busy(busy),
  .done(done), .host_addr(host_addr), .host_rdata(host_rdata)
);

// File: tb/sim_vec_lasu.sv
`timescale 1ns/1ps
module sim_vec_lasu;
  localparam int NREG = 128;
  localparam int AW   = 7;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, host_we = 1'b0;
  logic [31:0] instr = '0, host_wdata = '0;
  logic [AW-1:0] host_addr = '0;
  logic busy, done;
  logic [31:0] host_rdata;

  always #5 clk = ~clk;

  vec_lasu u0 (.clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .busy(busy), .done(done), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata));

  int n_chk = 0, n_bad = 0;
  bit reported = 0;
  logic [31:0] m [NREG];

  function automatic logic [31:0] enc(input logic [3:0] g, input logic [3:0] c,
      input logic [2:0] o, input logic [6:0] sa, input logic [6:0] d, input logic [6:0] sb);
    return {g, c, o, sa, d, sb};
  endfunction

  localparam int NP = 30;
  localparam logic [31:0] PROG [NP] = '{
    enc(4'hB, 4'd3, 3'd0, 7'd10, 7'd40, 7'd20),  // R5 AND vector
    enc(4'hB, 4'd2, 3'd1, 7'd11, 7'd44, 7'd5),   // R5 R4 AND scalar
    enc(4'hB, 4'd1, 3'd2, 7'd12, 7'd48, 7'h55),  // R5 R4 AND negative immediate
    enc(4'hB, 4'd3, 3'd3, 7'd13, 7'd50, 7'd21),  // R5 XOR vector
    enc(4'hB, 4'd2, 3'd4, 7'd14, 7'd54, 7'd6),   // R5 XOR scalar
    enc(4'hB, 4'd2, 3'd5, 7'd15, 7'd57, 7'h0F),  // R5 XOR positive immediate
    enc(4'hB, 4'd3, 3'd6, 7'd16, 7'd60, 7'd22),  // R5 OR vector
    enc(4'hB, 4'd1, 3'd7, 7'd17, 7'd64, 7'd7),   // R5 OR scalar
    enc(4'hA, 4'd3, 3'd0, 7'd18, 7'd66, 7'd23),  // R6 add vector
    enc(4'hA, 4'd2, 3'd1, 7'd19, 7'd70, 7'd8),   // R6 add scalar
    enc(4'hA, 4'd2, 3'd2, 7'd20, 7'd73, 7'h7F),  // R6 R4 add immediate -1
    enc(4'hA, 4'd3, 3'd4, 7'd21, 7'd76, 7'd24),  // R6 subtract vector
    enc(4'hA, 4'd2, 3'd5, 7'd22, 7'd80, 7'd9),   // R6 subtract scalar
    enc(4'hA, 4'd2, 3'd6, 7'd23, 7'd83, 7'h40),  // R6 R4 subtract immediate -64
    enc(4'hA, 4'd15,3'd3, 7'd30, 7'd86, 7'd3),   // R7 sum of 16 plus scalar
    enc(4'hA, 4'd7, 3'd7, 7'd0,  7'd88, 7'd30),  // R8 absolute value
    enc(4'hC, 4'd3, 3'd0, 7'd31, 7'd96, 7'd25),  // R9 logical right vector
    enc(4'hC, 4'd1, 3'd1, 7'd32, 7'd100,7'd4),   // R9 logical right immediate
    enc(4'hC, 4'd3, 3'd2, 7'd33, 7'd102,7'd26),  // R9 arithmetic right vector
    enc(4'hC, 4'd1, 3'd3, 7'd34, 7'd106,7'd31),  // R9 arithmetic right imm 31
    enc(4'hC, 4'd3, 3'd4, 7'd35, 7'd108,7'd27),  // R9 left vector
    enc(4'hC, 4'd1, 3'd5, 7'd36, 7'd112,7'h63),  // R9 left immediate, amount 3
    enc(4'hC, 4'd3, 3'd6, 7'd37, 7'd114,7'd10),  // R10 funnel by scalar register
    enc(4'hC, 4'd2, 3'd7, 7'd38, 7'd118,7'd0),   // R10 funnel amount 0
    enc(4'hC, 4'd2, 3'd7, 7'd39, 7'd121,7'd31),  // R10 funnel amount 31
    enc(4'hA, 4'd4, 3'd0, 7'd124,7'd125,7'd1),   // R3 R12 wrap onto R0
    enc(4'hA, 4'd3, 3'd0, 7'd60, 7'd61, 7'd70),  // R11 chained overlap
    enc(4'hC, 4'd3, 3'd7, 7'd41, 7'd40, 7'd5),   // R11 funnel reading ahead of writes
    enc(4'h9, 4'd5, 3'd0, 7'd10, 7'd11, 7'd12),  // R13 other group writes nothing
    enc(4'hA, 4'd0, 3'd7, 7'd0,  7'd0,  7'd50)   // R12 R8 single element to R0
  };
  localparam int PREQ [NP] = '{5,5,5,5,5,5,5,5,6,6,6,6,6,6,7,8,9,9,9,9,9,9,10,10,10,3,11,11,13,12};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
    $finish;
  endtask

  task automatic host_wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
    if (a != 0) m[a] = d;
  endtask

  task automatic model(input logic [31:0] ins);
    logic [3:0] g; logic [3:0] c; logic [2:0] o;
    logic [6:0] fa, fd, fb;
    logic [31:0] acc, a, a1, bv, bs, im, b, r;
    logic [63:0] w;
    g = ins[31:28]; c = ins[27:24]; o = ins[23:21];
    fa = ins[20:14]; fd = ins[13:7]; fb = ins[6:0];
    im = {{25{ins[6]}}, ins[6:0]};
    acc = m[fb];
    for (int e = 0; e <= int'(c); e++) begin
      logic [6:0] ai, di, bi;
      ai = fa + 7'(e); di = fd + 7'(e); bi = fb + 7'(e);
      a = m[ai]; a1 = m[ai + 7'd1]; bv = m[bi]; bs = m[fb];
      r = 'x;
      if (g == 4'hB) begin
        case (o)
          3'd0: r = a & bv;  3'd1: r = a & bs;  3'd2: r = a & im;
          3'd3: r = a ^ bv;  3'd4: r = a ^ bs;  3'd5: r = a ^ im;
          3'd6: r = a | bv;  default: r = a | bs;
        endcase
      end else if (g == 4'hA) begin
        case (o)
          3'd0: r = a + bv;  3'd1: r = a + bs;  3'd2: r = a + im;
          3'd4: r = a - bv;  3'd5: r = a - bs;  3'd6: r = a - im;
          3'd7: r = bv[31] ? a - bv : a + bv;
          default: acc = acc + a;
        endcase
      end else if (g == 4'hC) begin
        b = (o == 3'd6) ? bs : (o[0] ? im : bv);
        w = {a, a1} << b[4:0];
        case (o[2:1])
          2'd0: r = a >> b[4:0];
          2'd1: r = $signed(a) >>> b[4:0];
          2'd2: r = a << b[4:0];
          default: r = w[63:32];
        endcase
      end
      if ((g == 4'hA || g == 4'hB || g == 4'hC) && !(g == 4'hA && o == 3'd3) && di != 0)
        m[di] = r;
    end
    if (g == 4'hA && o == 3'd3 && fd != 0) m[fd] = acc;
  endtask

  task automatic compare_all(input string tag);
    for (int r = 0; r < NREG; r++) begin
      @(negedge clk);
      host_addr = 7'(r);
      #1;
      chk(host_rdata === m[r], $sformatf("%s reg %0d", tag, r), host_rdata, m[r]);
    end
  endtask

  task automatic issue(input logic [31:0] ins, input string tag);
    int k;
    @(negedge clk);
    start = 1'b1; instr = ins;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, {tag, " R2 busy after start"}, 32'(busy), 1);
    k = 0;
    while (k < 40) begin
      @(negedge clk);
      k++;
      if (done) break;
    end
    chk(k == int'(ins[27:24]) + 1, {tag, " R2 cycles to done"}, 32'(k), 32'(ins[27:24]) + 1);
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, {tag, " R2 idle after done"}, {busy, done}, 0);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int r = 0; r < NREG; r++) m[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk(busy === 1'b0 && done === 1'b0, "R1 busy/done after reset", {busy, done}, 0);
    compare_all("R1 cleared");
    // R12: host write to R0 dropped
    host_wr(7'd0, 32'hDEADBEEF);
    host_addr = 7'd0; #1;
    chk(host_rdata === 32'h0, "R12 host write to R0", host_rdata, 0);
    for (int r = 1; r < NREG; r++)
      host_wr(7'(r), (32'(r) * 32'h9E3779B9) ^ (32'(r) << 27) ^ 32'h0000_5A3C);
    compare_all("R12 preload");
    for (int p = 0; p < NP; p++) begin
      string tag;
      tag = $sformatf("R%0d prog %0d", PREQ[p], p);
      issue(PROG[p], tag);
      model(PROG[p]);
      compare_all(tag);
    end
    // R2 and R13: start and host write while busy are ignored
    begin
      int k;
      logic [31:0] first, second;
      first  = enc(4'hB, 4'd5, 3'd6, 7'd1, 7'd20, 7'd30);
      second = enc(4'hA, 4'd0, 3'd0, 7'd1, 7'd100, 7'd2);
      @(negedge clk);
      start = 1'b1; instr = first;
      @(negedge clk);
      instr = second; host_we = 1'b1; host_addr = 7'd100; host_wdata = 32'h0BAD_F00D;
      @(negedge clk);
      start = 1'b0; host_we = 1'b0;
      k = 1;
      while (k < 40) begin
        @(negedge clk);
        k++;
        if (done) break;
      end
      chk(k == 6, "R2 start while busy ignored, length", 32'(k), 6);
      @(negedge clk);
      chk(busy === 1'b0, "R2 no second run", 32'(busy), 0);
      model(first);
      compare_all("R13 host write while busy");
    end
    summary();
  end
endmodule